// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken. The guess comes from the recent outcomes of that same branch. A small tagged table is selected by low word-address bits. Each of its rows holds a partial tag and a shift register of the branch's last outcomes. That history selects one entry of a shared table of 2-bit saturating counters, and the upper bit of the counter is the guess. A build-time option sets how the counter index is formed:

- from the history alone,
- from the history with a few address bits appended, or
- from the history XORed with address bits.

A fetch stage presents a branch address on the lookup port and gets back a hit flag and a taken flag in the same cycle, with no register on the path. When the branch resolves, an execution stage presents its address and real outcome on the resolution port. On the next clock edge a tag hit trains the counter and shifts the history, and a tag miss claims the row for the new branch.

Top module: `lhp_top`

## Requirements
- R1: After reset every row of the history table is empty, so every lookup misses, and every counter holds 2'b10 (weakly taken).
- R2: A lookup whose row is empty or whose stored tag differs reports hit=0 and taken=0.
- R3: A resolution that misses writes, at the next edge, the branch's tag and an all-zero history into its row, marks the row valid and leaves every counter unchanged.
- R4: A resolution that hits shifts the row's history left by one, with the actual outcome entering bit 0 and the oldest bit dropping out.
- R5: Counters use 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken resolution that hits adds one to the indexed counter and stops at 11.
- R6: A not-taken resolution that hits subtracts one from the indexed counter and stops at 00.
- R7: On a hit the taken output equals bit 1 of the counter that the current history and address select.
- R8: In plain mode (MODE=IDX_HIST) the counter index is the history itself (2^HIST_W counters).
- R9: In concatenate mode (MODE=IDX_CAT) the counter index is {history, word-address bits [CAT_BITS-1:0]} (2^(HIST_W+CAT_BITS) counters).
- R10: In XOR mode (MODE=IDX_XOR) the counter index is the history XORed with word-address bits [HIST_W-1:0] (2^HIST_W counters).
- R11: Address bits [1:0] are ignored. The row is address bits [2 +: log2(ENTRIES)] and the tag is the next TAG_W bits. A different tag in an occupied row misses and replaces the row when it resolves.
- R12: A lookup in the same cycle as a resolution of the same branch sees the state before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_hit | output | 1 | A history row exists for lk_addr |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| rs_valid | input | 1 | A branch resolution is presented this cycle |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome (1 = taken) |

## Verification
The bench builds three copies of the block, one per index mode. Each copy has an 8-bit address, four history rows, a 2-bit tag, a 3-bit history and one appended address bit. At this size the bench can look up every address after reset. The 8 or 16 counters also saturate at both ends, and branches in different rows alias onto each other's counters again and again. Directed streams (constant, alternating, loop-shaped) are followed by a long pseudo-random sweep. Each cycle the bench compares every output with a bench-side table model.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

   typedef enum logic [1:0] {
      IDX_HIST = 2'd0,
      IDX_CAT  = 2'd1,
      IDX_XOR  = 2'd2
   } idx_mode_e;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_SNT = 2'b00;
   localparam ctr2_t CTR_WNT = 2'b01;
   localparam ctr2_t CTR_WT  = 2'b10;
   localparam ctr2_t CTR_ST  = 2'b11;

   function automatic ctr2_t ctr_step(input ctr2_t c, input logic taken);
      ctr2_t r;
      if (taken) r = (c == CTR_ST)  ? CTR_ST  : ctr2_t'(c + 2'd1);
      else       r = (c == CTR_SNT) ? CTR_SNT : ctr2_t'(c - 2'd1);
      return r;
   endfunction

endpackage

// File: rtl/lhp_index_fn.sv
module lhp_index_fn
   import lhp_pkg::*;
#(
   parameter idx_mode_e MODE     = IDX_XOR,
   parameter int        HIST_W   = 6,
   parameter int        CAT_BITS = 2,
   parameter int        LO_W     = 6,
   parameter int        IDX_W    = 6
) (
   input  logic [HIST_W-1:0] hist,
   input  logic [LO_W-1:0]   addr_lo,
   output logic [IDX_W-1:0]  idx
);

   logic unused_lo;
   assign unused_lo = ^addr_lo;

   generate
      if (MODE == IDX_CAT) begin : g_cat
         if (IDX_W != HIST_W + CAT_BITS) $error("concat index width mismatch");
         if (LO_W < CAT_BITS)            $error("too few low address bits");
         assign idx = {hist, addr_lo[CAT_BITS-1:0]};
      end else if (MODE == IDX_XOR) begin : g_xor
         if (IDX_W != HIST_W) $error("xor index width mismatch");
         if (LO_W < HIST_W)   $error("too few low address bits");
         assign idx = hist ^ addr_lo[HIST_W-1:0];
      end else begin : g_hist
         if (IDX_W != HIST_W) $error("plain index width mismatch");
         assign idx = hist;
      end
   endgenerate

endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
   import lhp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             up_en,
   input  logic [IDX_W-1:0] up_idx,
   input  logic             up_taken
);

   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) $error("counter index width out of range");

   ctr2_t ctr_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WT;
      end else if (up_en) begin
         ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
      end
   end

   assign rd_ctr = ctr_q[rd_idx];

   // R5: taken training counts up, holding at strong taken
   a_r5_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
      up_en && up_taken && ctr_q[up_idx] == CTR_ST |=> ctr_q[$past(up_idx)] == CTR_ST);
   a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
      up_en && up_taken && ctr_q[up_idx] != CTR_ST
      |=> ctr_q[$past(up_idx)] == ctr2_t'($past(ctr_q[up_idx]) + 2'd1));
   // R6: not-taken training counts down, holding at strong not-taken
   a_r6_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
      up_en && !up_taken && ctr_q[up_idx] == CTR_SNT |=> ctr_q[$past(up_idx)] == CTR_SNT);
   a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
      up_en && !up_taken && ctr_q[up_idx] != CTR_SNT
      |=> ctr_q[$past(up_idx)] == ctr2_t'($past(ctr_q[up_idx]) - 2'd1));

endmodule

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
   parameter int ENTRIES = 1024,
   parameter int TAG_W   = 8,
   parameter int HIST_W  = 6,
   localparam int SET_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  lk_set,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              rs_valid,
   input  logic [SET_W-1:0]  rs_set,
   input  logic [TAG_W-1:0]  rs_tag,
   input  logic              rs_taken,
   output logic              rs_hit,
   output logic [HIST_W-1:0] rs_hist
);

   if (ENTRIES < 2 || (1 << SET_W) != ENTRIES) $error("ENTRIES must be a power of two");
   if (HIST_W < 2) $error("HIST_W must be at least 2");
   if (TAG_W < 1)  $error("TAG_W must be at least 1");

   logic [ENTRIES-1:0] valid_v;
   logic [TAG_W-1:0]   tag_a  [ENTRIES];
   logic [HIST_W-1:0]  hist_a [ENTRIES];

   genvar e;
   generate
      for (e = 0; e < ENTRIES; e++) begin : g_row
         logic              v_q;
         logic [TAG_W-1:0]  t_q;
         logic [HIST_W-1:0] h_q;
         logic              wr;

         assign wr = rs_valid && (rs_set == SET_W'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  v_q <= 1'b0;
            else if (wr) v_q <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (wr) begin
               t_q <= rs_tag;
               h_q <= rs_hit ? {h_q[HIST_W-2:0], rs_taken} : '0;
            end
         end

         assign valid_v[e] = v_q;
         assign tag_a[e]   = t_q;
         assign hist_a[e]  = h_q;
      end
   endgenerate

   assign lk_hit  = valid_v[lk_set] && (tag_a[lk_set] == lk_tag);
   assign lk_hist = hist_a[lk_set];
   assign rs_hit  = valid_v[rs_set] && (tag_a[rs_set] == rs_tag);
   assign rs_hist = hist_a[rs_set];

   // R4: a trained row shifts in the outcome at bit 0
   a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && rs_hit
      |=> hist_a[$past(rs_set)] == {$past(rs_hist[HIST_W-2:0]), $past(rs_taken)});
   // R3: a missed branch claims its row with a clean history
   a_r3_alloc_row: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && !rs_hit
      |=> valid_v[$past(rs_set)] && tag_a[$past(rs_set)] == $past(rs_tag)
          && hist_a[$past(rs_set)] == '0);

endmodule

// File: rtl/lhp_top.sv
module lhp_top
   import lhp_pkg::*;
#(
   parameter int        ADDR_W   = 32,
   parameter int        ENTRIES  = 1024,
   parameter int        TAG_W    = 8,
   parameter int        HIST_W   = 6,
   parameter int        CAT_BITS = 2,
   parameter idx_mode_e MODE     = IDX_XOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic              lk_taken,
   input  logic              rs_valid,
   input  logic [ADDR_W-1:0] rs_addr,
   input  logic              rs_taken
);

   localparam int SET_W  = $clog2(ENTRIES);
   localparam int LO_W   = (HIST_W > CAT_BITS) ? HIST_W : CAT_BITS;
   localparam int CIDX_W = (MODE == IDX_CAT) ? HIST_W + CAT_BITS : HIST_W;

   if (ADDR_W < 2 + SET_W + TAG_W) $error("ADDR_W too small for row and tag");
   if (ADDR_W < 2 + LO_W)          $error("ADDR_W too small for index bits");
   if (CAT_BITS < 1)               $error("CAT_BITS must be at least 1");

   logic [SET_W-1:0]  lk_set, rs_set;
   logic [TAG_W-1:0]  lk_tag, rs_tag;
   logic [LO_W-1:0]   lk_lo, rs_lo;
   logic [HIST_W-1:0] lk_hist, rs_hist;
   logic              rs_hit;
   logic [CIDX_W-1:0] lk_idx, rs_idx;
   ctr2_t             lk_ctr;

   assign lk_set = lk_addr[2 +: SET_W];
   assign rs_set = rs_addr[2 +: SET_W];
   assign lk_tag = lk_addr[2 + SET_W +: TAG_W];
   assign rs_tag = rs_addr[2 + SET_W +: TAG_W];
   assign lk_lo  = lk_addr[2 +: LO_W];
   assign rs_lo  = rs_addr[2 +: LO_W];

   logic unused_bits;
   assign unused_bits = ^{lk_addr, rs_addr, lk_ctr[0]};

   lhp_hist_table #(
      .ENTRIES (ENTRIES),
      .TAG_W   (TAG_W),
      .HIST_W  (HIST_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_set   (lk_set),
      .lk_tag   (lk_tag),
      .lk_hit   (lk_hit),
      .lk_hist  (lk_hist),
      .rs_valid (rs_valid),
      .rs_set   (rs_set),
      .rs_tag   (rs_tag),
      .rs_taken (rs_taken),
      .rs_hit   (rs_hit),
      .rs_hist  (rs_hist)
   );

   lhp_index_fn #(
      .MODE (MODE), .HIST_W (HIST_W), .CAT_BITS (CAT_BITS), .LO_W (LO_W), .IDX_W (CIDX_W)
   ) u_lk_idx (
      .hist    (lk_hist),
      .addr_lo (lk_lo),
      .idx     (lk_idx)
   );

   lhp_index_fn #(
      .MODE (MODE), .HIST_W (HIST_W), .CAT_BITS (CAT_BITS), .LO_W (LO_W), .IDX_W (CIDX_W)
   ) u_rs_idx (
      .hist    (rs_hist),
      .addr_lo (rs_lo),
      .idx     (rs_idx)
   );

   lhp_ctr_table #(
      .IDX_W (CIDX_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_ctr   (lk_ctr),
      .up_en    (rs_valid && rs_hit),
      .up_idx   (rs_idx),
      .up_taken (rs_taken)
   );

   assign lk_taken = lk_hit & lk_ctr[1];

   // R2: a missing branch is never predicted taken
   a_r2_miss_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> !lk_taken);

endmodule

// File: tb/sim_lhp_top.sv
module sim_lhp_top;
   import lhp_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] lk_addr, rs_addr;
   logic       rs_valid, rs_taken;
   logic [2:0] hit, tk;

   always #10 clk = ~clk;

   lhp_top #(.ADDR_W(8), .ENTRIES(4), .TAG_W(2), .HIST_W(3), .CAT_BITS(1), .MODE(IDX_XOR)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(hit[0]), .lk_taken(tk[0]),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken));
   lhp_top #(.ADDR_W(8), .ENTRIES(4), .TAG_W(2), .HIST_W(3), .CAT_BITS(1), .MODE(IDX_CAT)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(hit[1]), .lk_taken(tk[1]),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken));
   lhp_top #(.ADDR_W(8), .ENTRIES(4), .TAG_W(2), .HIST_W(3), .CAT_BITS(1), .MODE(IDX_HIST)) u2 (
      .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(hit[2]), .lk_taken(tk[2]),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken));

   // bench-side model of the tables
   logic       mv   [4];
   logic [1:0] mtag [4];
   logic [2:0] mh   [4];
   logic [1:0] mc   [3][16];
   int         vec = 0;
   int         bad = 0;

   function automatic int midx(int m, logic [2:0] h, logic [7:0] a);
      case (m)
         0:       return int'(h ^ a[4:2]);   // R10
         1:       return int'({h, a[2]});    // R9
         default: return int'(h);            // R8
      endcase
   endfunction

   function automatic string mname(int m);
      case (m)
         0:       return "R10 xor";
         1:       return "R9 concat";
         default: return "R8 plain";
      endcase
   endfunction

   task automatic chk(logic act, logic exp, string tag);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic step(logic [7:0] a, logic res, logic t, string tag);
      int  s;
      logic h;
      @(negedge clk);
      lk_addr  = a;
      rs_addr  = a;
      rs_valid = res;
      rs_taken = t;
      #1;
      s = int'(a[3:2]);                       // R11 row bits
      h = mv[s] && (mtag[s] == a[5:4]);       // R11 tag bits
      for (int m = 0; m < 3; m++) begin
         chk(hit[m], h, $sformatf("%s %s hit addr=%02h", tag, mname(m), a));
         chk(tk[m], h ? mc[m][midx(m, mh[s], a)][1] : 1'b0,
             $sformatf("%s R7 %s taken addr=%02h", tag, mname(m), a));
      end
      if (res) begin
         if (h) begin
            for (int m = 0; m < 3; m++) begin
               int i;
               i = midx(m, mh[s], a);
               if (t) mc[m][i] = (mc[m][i] == 2'b11) ? 2'b11 : mc[m][i] + 2'd1;  // R5
               else   mc[m][i] = (mc[m][i] == 2'b00) ? 2'b00 : mc[m][i] - 2'd1;  // R6
            end
            mh[s] = {mh[s][1:0], t};          // R4
         end else begin
            mv[s]   = 1'b1;                   // R3
            mtag[s] = a[5:4];
            mh[s]   = 3'b000;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      rst_n    = 1'b0;
      lk_addr  = '0;
      rs_addr  = '0;
      rs_valid = 1'b0;
      rs_taken = 1'b0;
      for (int s = 0; s < 4; s++) begin
         mv[s] = 1'b0; mtag[s] = '0; mh[s] = '0;
      end
      for (int m = 0; m < 3; m++)
         for (int i = 0; i < 16; i++) mc[m][i] = 2'b10;   // R1
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 R2: whole address space misses after reset, low bits included
      for (int a = 0; a < 256; a++) step(8'(a), 1'b0, 1'b0, "R1 R2 reset-miss");

      // R3: allocate, then hit with weakly-taken counters
      step(8'h14, 1'b1, 1'b1, "R3 allocate");
      step(8'h14, 1'b0, 1'b0, "R3 after-allocate");
      step(8'h17, 1'b0, 1'b0, "R11 low-bits-ignored");
      // R11: same row, other tag
      step(8'h24, 1'b0, 1'b0, "R11 tag-mismatch");
      step(8'h24, 1'b1, 1'b0, "R11 replace");
      step(8'h14, 1'b0, 1'b0, "R11 evicted");
      step(8'h24, 1'b0, 1'b0, "R11 new-owner");

      // R5: long taken streak
      step(8'h30, 1'b1, 1'b1, "R3 allocate");
      for (int k = 0; k < 12; k++) step(8'h30, 1'b1, 1'b1, "R5 R4 taken-streak");
      // R6: long not-taken streak
      for (int k = 0; k < 12; k++) step(8'h30, 1'b1, 1'b0, "R6 R4 nt-streak");
      // R7: loop shaped TTTN
      step(8'h08, 1'b1, 1'b1, "R3 allocate");
      for (int k = 0; k < 40; k++) step(8'h08, 1'b1, (k % 4) != 3, "R7 R4 loop");
      // R12: same branch looked up while resolving
      step(8'h3C, 1'b1, 1'b0, "R3 allocate");
      for (int k = 0; k < 24; k++) step(8'h3C, 1'b1, k[0], "R12 R4 alternating");

      // pseudo-random sweep
      lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[7:0], lfsr[9] | lfsr[10], lfsr[8] ^ (lfsr[2] & lfsr[3]),
              "R4 R5 R6 R11 R12 sweep");
      end

      @(negedge clk);
      rs_valid = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule